// File: doc/BRIEF.md
# Decimal Byte Display Driver for Four Multiplexed Seven-Segment Digits

This block turns a byte into a decimal readout on four seven-segment digits that share one set of segment lines. A byte is stored when the load strobe is high. A mode input selects how the stored byte is read. In unsigned mode the readout covers 0 to 255. In signed mode the byte is two's complement, covering -128 to 127. A negative number shows its magnitude, and the leftmost digit shows a minus sign.

The conversion from binary to decimal is done in logic. A refresh counter drives the digits one at a time, with each digit lit for a fixed number of clock cycles. The block converts the stored byte and the current mode only at the boundary of a full scan. Every scan therefore shows one consistent number, and the change never appears partway through a scan.

Top module: `dec_byte_display`

## Requirements
- R1: While reset is high, `dig_en` is 4'b0001 and `seg` is 0, and the stored byte is cleared. Until the first full-scan boundary all digits are blank. After that boundary the display reads "   0" (three blanks, then 0).
- R2: Exactly one bit of `dig_en` is high at any time. Bit 0 drives the ones digit and bit 3 drives the leftmost digit. The enable steps from bit 0 to bit 1, bit 2, bit 3 and back to bit 0. Each bit stays high for SCAN_DIV consecutive cycles.
- R3: `seg` is active high, with bit 0 driving segment a through bit 6 driving segment g. The digit codes in hex are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. A minus sign is 40 and a blank digit is 00.
- R4: In unsigned mode (`signed_mode`=0) the three right digits show the stored byte in decimal, from 0 to 255. The leftmost digit is blank.
- R5: A leading zero is blanked in the hundreds position, and in the tens position when the hundreds digit is also zero. A zero inside the number is shown, so 205 reads " 205". The ones digit is never blank.
- R6: In signed mode with bit 7 of the byte set, the leftmost digit shows the minus sign. The right digits show the magnitude, so 0x80 reads "-128", 0xFF reads "-  1" and 0xF6 reads "- 10".
- R7: In signed mode with bit 7 clear, the readout is the same as in unsigned mode, with a blank leftmost digit (0x7F reads " 127").
- R8: `din` is stored only in a cycle where `load` is high. Changes on `din` while `load` is low do not alter the readout.
- R9: The stored byte and `signed_mode` are converted only at a full-scan boundary. `seg` changes only when `dig_en` changes. A change of mode without a new load shows the same byte under the new reading from the next scan on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Store strobe for `din` |
| din | input | 8 | Byte to display |
| signed_mode | input | 1 | 1: two's-complement reading, 0: unsigned reading |
| seg | output | 7 | Segment drive, bit 0 = a … bit 6 = g, active high |
| dig_en | output | 4 | One-hot digit enable, bit 0 = ones, bit 3 = leftmost |

## Verification
The assertions assume that `load`, `din` and `signed_mode` are synchronous to `clk`. They also assume that reset is held for at least one clock edge before any property is evaluated, so every `$past` value comes from a cycle in or after reset. The stimulus changes every input only on the falling clock edge, holds `load` high for exactly one cycle, and changes `signed_mode` freely because the block samples it only at a scan boundary. Each expected readout is taken from the first complete scan that starts at least two scans after the stimulus, so the boundary latency never falls inside the window being compared.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_BLANK = 7'h00;
  localparam seg_t SEG_MINUS = 7'h40;

  // Count of decimal digits needed for the largest unsigned value of w bits
  function automatic int dec_digits(input int w);
    longint v;
    int n;
    v = (longint'(1) << w) - 1;
    n = 1;
    v = v / 10;
    while (v > 0) begin
      n++;
      v = v / 10;
    end
    return n;
  endfunction

  // Segment pattern for one BCD digit, bit0 = a ... bit6 = g
  function automatic seg_t digit_glyph(input logic [3:0] d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return SEG_BLANK;
    endcase
  endfunction

endpackage

// File: rtl/sdd_bin2bcd.sv
module sdd_bin2bcd #(
  parameter int IN_W = 8,
  parameter int DEC_DIGITS = 3,
  localparam int SHW = IN_W + 4 * DEC_DIGITS
) (
  input  logic [IN_W-1:0]         bin,
  output logic [4*DEC_DIGITS-1:0] bcd
);

  logic [SHW-1:0] sh;

  // Shift-and-add-3 conversion, fully unrolled
  always_comb begin
    sh = '0;
    sh[IN_W-1:0] = bin;
    for (int i = 0; i < IN_W; i++) begin
      for (int k = 0; k < DEC_DIGITS; k++) begin
        if (sh[IN_W+4*k +: 4] >= 4'd5)
          sh[IN_W+4*k +: 4] = sh[IN_W+4*k +: 4] + 4'd3;
      end
      sh = sh << 1;
    end
    bcd = sh[SHW-1:IN_W];
  end

endmodule

// File: rtl/sdd_format.sv
module sdd_format
  import sdd_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DEC_DIGITS = sdd_pkg::dec_digits(DATA_W),
  localparam int NUM_DIGITS = DEC_DIGITS + 1
) (
  input  logic [DATA_W-1:0]         value,
  input  logic                      signed_mode,
  output seg_t [NUM_DIGITS-1:0]     glyphs
);

  logic                    neg;
  logic [DATA_W-1:0]       mag;
  logic [4*DEC_DIGITS-1:0] bcd;

  assign neg = signed_mode & value[DATA_W-1];
  assign mag = neg ? (~value + DATA_W'(1)) : value;

  sdd_bin2bcd #(
    .IN_W      (DATA_W),
    .DEC_DIGITS(DEC_DIGITS)
  ) u_conv (
    .bin(mag),
    .bcd(bcd)
  );

  always_comb begin
    logic lead;
    logic [3:0] nib;
    glyphs = '0;
    lead   = 1'b1;
    for (int k = DEC_DIGITS - 1; k >= 1; k--) begin
      nib = bcd[4*k +: 4];
      if (lead && nib == 4'd0) begin
        glyphs[k] = SEG_BLANK;
      end else begin
        lead      = 1'b0;
        glyphs[k] = digit_glyph(nib);
      end
    end
    glyphs[0]          = digit_glyph(bcd[3:0]);
    glyphs[DEC_DIGITS] = neg ? SEG_MINUS : SEG_BLANK;
  end

endmodule

// File: rtl/sdd_scan.sv
module sdd_scan #(
  parameter int NUM_DIGITS = 4,
  parameter int SCAN_DIV = 4096,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx,
  output logic             wrap
);

  logic [DIV_W-1:0] div_q;
  logic             step;

  assign step = (div_q == DIV_W'(SCAN_DIV - 1));
  assign wrap = step && (idx == IDX_W'(NUM_DIGITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      idx   <= '0;
    end else if (step) begin
      div_q <= '0;
      idx   <= (idx == IDX_W'(NUM_DIGITS - 1)) ? '0 : idx + IDX_W'(1);
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(idx) < NUM_DIGITS);

endmodule

// File: rtl/dec_byte_display.sv
module dec_byte_display
  import sdd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SCAN_DIV = 4096,
  localparam int DEC_DIGITS = sdd_pkg::dec_digits(DATA_W),
  localparam int NUM_DIGITS = DEC_DIGITS + 1,
  localparam int IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [DATA_W-1:0]     din,
  input  logic                  signed_mode,
  output logic [6:0]            seg,
  output logic [NUM_DIGITS-1:0] dig_en
);

  logic [DATA_W-1:0]     val_q;
  seg_t [NUM_DIGITS-1:0] glyphs;
  seg_t [NUM_DIGITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx;
  logic                  wrap;
  seg_t                  seg_q;
  logic [NUM_DIGITS-1:0] en_q;

  sdd_format #(.DATA_W(DATA_W)) u_fmt (
    .value      (val_q),
    .signed_mode(signed_mode),
    .glyphs     (glyphs)
  );

  sdd_scan #(
    .NUM_DIGITS(NUM_DIGITS),
    .SCAN_DIV  (SCAN_DIV)
  ) u_scan (
    .clk (clk),
    .rst (rst),
    .idx (idx),
    .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= '0;
      frame_q <= '0;
      seg_q   <= SEG_BLANK;
      en_q    <= NUM_DIGITS'(1);
    end else begin
      if (load) val_q <= din;
      if (wrap) frame_q <= glyphs;
      seg_q <= frame_q[idx];
      en_q  <= NUM_DIGITS'(1) << idx;
    end
  end

  assign seg    = seg_q;
  assign dig_en = en_q;

  assert_one_enable_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(dig_en) == 1);

  assert_enable_rotates_R2: assert property (@(posedge clk) disable iff (rst)
    (dig_en != $past(dig_en)) |->
      (dig_en == {$past(dig_en[NUM_DIGITS-2:0]), $past(dig_en[NUM_DIGITS-1])}));

  assert_seg_holds_in_slot_R9: assert property (@(posedge clk) disable iff (rst)
    $stable(dig_en) |-> $stable(seg));

  assert_value_held_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(val_q));

  assert_ones_shown_R5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (frame_q[0] != SEG_BLANK));

  assert_minus_iff_negative_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ((frame_q[NUM_DIGITS-1] == SEG_MINUS) ==
              $past(signed_mode && val_q[DATA_W-1])));

endmodule

// File: tb/tb_dec_byte_display.sv
module tb_dec_byte_display;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int SETTLE = 2 * 4 * DIV + 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] din = '0;
  logic       signed_mode = 1'b0;
  logic [6:0] seg;
  logic [3:0] dig_en;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int served = 0;
  logic [7:0] held = '0;

  logic [27:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dec_byte_display #(.DATA_W(8), .SCAN_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .load(load), .din(din),
    .signed_mode(signed_mode), .seg(seg), .dig_en(dig_en)
  );

  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  // Digit 0 in bits [6:0] (ones) ... digit 3 in bits [27:21] (leftmost)
  function automatic logic [27:0] expect_frame(input logic [7:0] v, input logic sm);
    int mag, h, t, o;
    logic neg;
    logic [27:0] f;
    neg = sm && v[7];
    mag = neg ? 256 - int'(v) : int'(v);
    h = mag / 100; t = (mag / 10) % 10; o = mag % 10;
    f[6:0]   = glyph(o);
    f[13:7]  = (h == 0 && t == 0) ? 7'h00 : glyph(t);
    f[20:14] = (h == 0) ? 7'h00 : glyph(h);
    f[27:21] = neg ? 7'h40 : 7'h00;
    return f;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply stimulus, then queue the readout the requirements predict
  task automatic drive(input logic [7:0] v, input logic sm, input bit ld, input string tag);
    @(negedge clk);
    din = v; signed_mode = sm; load = ld;
    if (ld) held = v;
    @(negedge clk);
    load = 1'b0;
    repeat (SETTLE) @(negedge clk);
    exp_q.push_back(expect_frame(held, sm));
    tag_q.push_back(tag);
    pushed++;
    wait (served == pushed);
  endtask

  // Monitor: capture one whole scan starting at the ones digit and compare
  initial begin
    forever begin
      logic [27:0] e;
      string t;
      logic [3:0] prev;
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      prev = dig_en;
      forever begin
        @(negedge clk);
        if (dig_en == 4'b0001 && prev == 4'b1000) break;
        prev = dig_en;
      end
      for (int d = 0; d < 4; d++) begin
        logic [6:0] s;
        int cnt;
        s = seg;
        check(s == e[7*d +: 7], t, $sformatf("R3 seg of digit %0d", d), s, e[7*d +: 7]);
        cnt = 0;
        while (dig_en == (4'b0001 << d)) begin
          cnt++;
          @(negedge clk);
        end
        check(cnt == DIV, t, $sformatf("R2 slot length of digit %0d", d), cnt, DIV);
        check(dig_en == (4'b0001 << ((d + 1) % 4)), t, "R2 next enable",
              dig_en, 4'b0001 << ((d + 1) % 4));
      end
      served++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dig_en == 4'b0001, "R1", "reset dig_en", dig_en, 1);
    check(seg == 7'h00, "R1", "reset seg", seg, 0);
    rst = 1'b0;
    // R1: cleared byte reads "   0"
    drive(8'd0, 1'b0, 1'b0, "R1");
    // R4: unsigned readings
    drive(8'd7, 1'b0, 1'b1, "R4");
    drive(8'd42, 1'b0, 1'b1, "R4");
    drive(8'd255, 1'b0, 1'b1, "R4");
    drive(8'd100, 1'b0, 1'b1, "R4");
    // R5: inner zero shown, leading zeros blanked
    drive(8'd205, 1'b0, 1'b1, "R5");
    drive(8'd9, 1'b0, 1'b1, "R5");
    // R6: negative signed readings
    drive(8'h80, 1'b1, 1'b1, "R6");
    drive(8'hFF, 1'b1, 1'b1, "R6");
    drive(8'hF6, 1'b1, 1'b1, "R6");
    // R7: non-negative signed readings
    drive(8'h7F, 1'b1, 1'b1, "R7");
    drive(8'h05, 1'b1, 1'b1, "R7");
    // R8: din moves without load, readout stays 123
    drive(8'd123, 1'b0, 1'b1, "R8");
    drive(8'd45, 1'b0, 1'b0, "R8");
    // R9: mode changes without reload, same byte read anew
    drive(8'd200, 1'b0, 1'b1, "R9");
    drive(8'd17, 1'b1, 1'b0, "R9");
    drive(8'd17, 1'b0, 1'b0, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule